// File: doc/BRIEF.md
# Best-Three Track Sorter With Duplicate Cancellation

This block takes nine assembled track candidates, delivered as three streams of three, and reports the three best distinct ones on the next clock edge. Each candidate carries a valid bit, a 6-bit rank (larger is better) and four 3-bit segment labels, one per detector station. A label names the input segment that the candidate used at that station, and the value zero means the station is not present in that candidate.

A single particle can be built more than once, by different streams. Before selection, the block therefore compares every pair of candidates that come from different streams and counts how many station labels they have in common. If that count is strictly greater than a programmable 2-bit threshold, the pair is judged to be one track and the weaker member is dropped. The three strongest survivors are then placed into ordered output slots together with their input index. Cancellation and selection share one combinational stage in front of the output register.

Candidate k (k = 0..8) belongs to stream k/3 (integer division). Its rank is `cand_rank[6k +: 6]`. Its label for station s (s = 0..3) is `cand_labels[12k + 3s +: 3]`. Output slot n (n = 0..2) uses `best_valid[n]`, `best_rank[6n +: 6]` and `best_idx[4n +: 4]`. Slot 0 is the best slot.

Top module: `best3_dedup_sorter`

## Requirements
- R1: While `rst_n` is low, every output bit is zero. This holds whatever the inputs are, and it takes effect without waiting for a clock edge.
- R2: The outputs change only at a rising clock edge. They reflect the inputs sampled at that edge, which is a latency of exactly one cycle, and input changes between edges do not affect them.
- R3: Valid slots are ordered by rank from slot 0 downward, with rank never increasing. Between equal ranks, the candidate with the lower input index takes the earlier slot.
- R4: Only candidates that are valid and not cancelled appear in the slots. Each appears at most once, with its own rank and an index in the range 0..8.
- R5: With fewer than three survivors, the valid slots are packed from slot 0 upward. Every unused slot has valid, rank and index all zero.
- R6: A station counts as shared between two candidates when their labels at that station are equal and nonzero. A zero label never counts as shared.
- R7: Two valid candidates from different streams are duplicates when their shared count is strictly greater than `dup_thresh`. A count equal to the threshold is not enough.
- R8: Candidates from the same stream are never compared, and they never cancel each other, even if all four labels match.
- R9: Of a duplicate pair, the candidate with the lower rank is cancelled. If the ranks are equal, the candidate with the higher index is cancelled. As a result, whenever any input is valid, at least one candidate survives.
- R10: All pairs are judged from the original valid bits at the same time. A candidate that is itself cancelled still cancels a weaker duplicate.
- R11: With `dup_thresh` = 3, only a pair that shares all four stations is a duplicate.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset, deasserted in step with clk |
| dup_thresh | input | 2 | Shared-station count that a pair must exceed to be treated as one track |
| cand_valid | input | 9 | Valid bit of each candidate |
| cand_rank | input | 54 | Ranks, 6 bits per candidate, candidate k at bits 6k+5..6k |
| cand_labels | input | 108 | Station labels, 12 bits per candidate, station s at bits 3s+2..3s within that field |
| best_valid | output | 3 | Valid bit of each output slot |
| best_rank | output | 18 | Rank of each slot, 6 bits per slot |
| best_idx | output | 12 | Input index of each slot, 4 bits per slot |

## Verification
The block holds no state apart from its output register, so a wrong cancellation or ranking decision is visible at the slots on the first edge after the offending inputs arrive, and it is gone one edge later. The table vectors are built so that a mistake shows up as a particular failure in the slots. A miscounted shared label or an off-by-one threshold compare either adds a candidate that should have been dropped or leaves a slot empty. An inverted tie rule swaps two slot indices. Comparing candidates within one stream removes a candidate that should survive. Assertions on the registered slots catch bad ordering, unpacked slots, non-zero empty slots and out-of-range indices in the cycle where they appear.

// File: rtl/tsort_pkg.sv
package tsort_pkg;
  // Default geometry shared by the sorter and its sub-blocks.
  localparam int DEF_STREAMS    = 3;
  localparam int DEF_PER_STREAM = 3;
  localparam int DEF_RANK_W     = 6;
  localparam int DEF_STATIONS   = 4;
  localparam int DEF_LABEL_W    = 3;
  localparam int DEF_THR_W      = 2;
  localparam int DEF_OUT_SLOTS  = 3;
endpackage

// File: rtl/tsort_share_count.sv
// Counts the stations at which two candidates carry the same nonzero label.
module tsort_share_count #(
  parameter int STATIONS = tsort_pkg::DEF_STATIONS,
  parameter int LABEL_W  = tsort_pkg::DEF_LABEL_W,
  parameter int CNT_W    = $clog2(STATIONS + 1)
) (
  input  logic [STATIONS*LABEL_W-1:0] lab_a,
  input  logic [STATIONS*LABEL_W-1:0] lab_b,
  output logic [CNT_W-1:0]            shared
);
  logic [STATIONS-1:0] hit;

  generate
    for (genvar s = 0; s < STATIONS; s++) begin : g_st
      logic [LABEL_W-1:0] a_s;
      logic [LABEL_W-1:0] b_s;
      assign a_s    = lab_a[s*LABEL_W +: LABEL_W];
      assign b_s    = lab_b[s*LABEL_W +: LABEL_W];
      // a zero label marks an absent station and never matches
      assign hit[s] = (a_s != '0) && (a_s == b_s);
    end
  endgenerate

  always_comb begin
    shared = '0;
    for (int s = 0; s < STATIONS; s++) begin
      shared = shared + CNT_W'(hit[s]);
    end
  end
endmodule

// File: rtl/tsort_cancel.sv
// Cross-stream duplicate detection and loser cancellation, all pairs at once.
module tsort_cancel #(
  parameter int N_CAND     = 9,
  parameter int PER_STREAM = tsort_pkg::DEF_PER_STREAM,
  parameter int RANK_W     = tsort_pkg::DEF_RANK_W,
  parameter int STATIONS   = tsort_pkg::DEF_STATIONS,
  parameter int LABEL_W    = tsort_pkg::DEF_LABEL_W,
  parameter int THR_W      = tsort_pkg::DEF_THR_W
) (
  input  logic [N_CAND-1:0]                   cand_valid,
  input  logic [N_CAND*RANK_W-1:0]            cand_rank,
  input  logic [N_CAND*STATIONS*LABEL_W-1:0]  cand_lab,
  input  logic [THR_W-1:0]                    thresh,
  output logic [N_CAND-1:0]                   survive
);
  localparam int LAB_W = STATIONS * LABEL_W;
  localparam int CNT_W = $clog2(STATIONS + 1);
  localparam int CMP_W = (CNT_W > THR_W) ? CNT_W : THR_W;
  localparam int PAIRS = N_CAND * N_CAND;

  // dup[a*N_CAND+b]  : a and b judged to be the same track (symmetric)
  // kill[v*N_CAND+k] : k removes v
  logic [PAIRS-1:0] dup;
  logic [PAIRS-1:0] kill;

  generate
    for (genvar i = 0; i < N_CAND; i++) begin : g_row
      for (genvar j = 0; j < N_CAND; j++) begin : g_col
        if (i < j && (i / PER_STREAM) != (j / PER_STREAM)) begin : g_cmp
          logic [CNT_W-1:0] cnt;
          tsort_share_count #(
            .STATIONS (STATIONS),
            .LABEL_W  (LABEL_W),
            .CNT_W    (CNT_W)
          ) u_share (
            .lab_a  (cand_lab[i*LAB_W +: LAB_W]),
            .lab_b  (cand_lab[j*LAB_W +: LAB_W]),
            .shared (cnt)
          );
          assign dup[i*N_CAND+j] = cand_valid[i] & cand_valid[j] &
                                   (CMP_W'(cnt) > CMP_W'(thresh));
        end else if (i > j) begin : g_mirror
          assign dup[i*N_CAND+j] = dup[j*N_CAND+i];
        end else begin : g_none
          // diagonal or same-stream pair: never compared
          assign dup[i*N_CAND+j] = 1'b0;
        end
      end
    end

    for (genvar v = 0; v < N_CAND; v++) begin : g_vic
      for (genvar k = 0; k < N_CAND; k++) begin : g_kil
        logic [RANK_W-1:0] r_v;
        logic [RANK_W-1:0] r_k;
        logic              v_loses;
        assign r_v     = cand_rank[v*RANK_W +: RANK_W];
        assign r_k     = cand_rank[k*RANK_W +: RANK_W];
        // lower rank loses; on a tie the higher index loses
        assign v_loses = (r_v < r_k) || ((r_v == r_k) && (v > k));
        assign kill[v*N_CAND+k] = dup[v*N_CAND+k] & v_loses;
      end
    end
  endgenerate

  always_comb begin
    for (int v = 0; v < N_CAND; v++) begin
      survive[v] = cand_valid[v] & ~(|kill[v*N_CAND +: N_CAND]);
    end
  end
endmodule

// File: rtl/tsort_select.sv
// Places the best survivors into ordered output slots by counting how many beat each one.
module tsort_select #(
  parameter int N_CAND    = 9,
  parameter int OUT_SLOTS = tsort_pkg::DEF_OUT_SLOTS,
  parameter int RANK_W    = tsort_pkg::DEF_RANK_W,
  parameter int IDX_W     = $clog2(N_CAND)
) (
  input  logic [N_CAND-1:0]          survive,
  input  logic [N_CAND*RANK_W-1:0]   cand_rank,
  output logic [OUT_SLOTS-1:0]       slot_valid,
  output logic [OUT_SLOTS*RANK_W-1:0] slot_rank,
  output logic [OUT_SLOTS*IDX_W-1:0] slot_idx
);
  localparam int POS_W = $clog2(N_CAND + 1);

  logic [N_CAND*POS_W-1:0] pos;

  generate
    for (genvar i = 0; i < N_CAND; i++) begin : g_pos
      logic [RANK_W-1:0] r_i;
      logic [POS_W-1:0]  beaten_by;
      assign r_i = cand_rank[i*RANK_W +: RANK_W];
      always_comb begin
        beaten_by = '0;
        for (int j = 0; j < N_CAND; j++) begin
          if (j != i && survive[j]) begin
            if ((cand_rank[j*RANK_W +: RANK_W] > r_i) ||
                ((cand_rank[j*RANK_W +: RANK_W] == r_i) && (j < i))) begin
              beaten_by = beaten_by + 1'b1;
            end
          end
        end
      end
      assign pos[i*POS_W +: POS_W] = beaten_by;
    end
  endgenerate

  // every survivor has a distinct position, so at most one drives each slot
  always_comb begin
    slot_valid = '0;
    slot_rank  = '0;
    slot_idx   = '0;
    for (int s = 0; s < OUT_SLOTS; s++) begin
      for (int i = 0; i < N_CAND; i++) begin
        if (survive[i] && (pos[i*POS_W +: POS_W] == POS_W'(s))) begin
          slot_valid[s]                 = 1'b1;
          slot_rank[s*RANK_W +: RANK_W] = cand_rank[i*RANK_W +: RANK_W];
          slot_idx[s*IDX_W +: IDX_W]    = IDX_W'(i);
        end
      end
    end
  end
endmodule

// File: rtl/best3_dedup_sorter.sv
module best3_dedup_sorter #(
  parameter int STREAMS    = tsort_pkg::DEF_STREAMS,
  parameter int PER_STREAM = tsort_pkg::DEF_PER_STREAM,
  parameter int RANK_W     = tsort_pkg::DEF_RANK_W,
  parameter int STATIONS   = tsort_pkg::DEF_STATIONS,
  parameter int LABEL_W    = tsort_pkg::DEF_LABEL_W,
  parameter int THR_W      = tsort_pkg::DEF_THR_W,
  parameter int OUT_SLOTS  = tsort_pkg::DEF_OUT_SLOTS,
  localparam int N_CAND    = STREAMS * PER_STREAM,
  localparam int IDX_W     = $clog2(N_CAND),
  localparam int LAB_W     = STATIONS * LABEL_W
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [THR_W-1:0]             dup_thresh,
  input  logic [N_CAND-1:0]            cand_valid,
  input  logic [N_CAND*RANK_W-1:0]     cand_rank,
  input  logic [N_CAND*LAB_W-1:0]      cand_labels,
  output logic [OUT_SLOTS-1:0]         best_valid,
  output logic [OUT_SLOTS*RANK_W-1:0]  best_rank,
  output logic [OUT_SLOTS*IDX_W-1:0]   best_idx
);
  logic [N_CAND-1:0]           survive;
  logic [OUT_SLOTS-1:0]        nxt_valid;
  logic [OUT_SLOTS*RANK_W-1:0] nxt_rank;
  logic [OUT_SLOTS*IDX_W-1:0]  nxt_idx;

  tsort_cancel #(
    .N_CAND     (N_CAND),
    .PER_STREAM (PER_STREAM),
    .RANK_W     (RANK_W),
    .STATIONS   (STATIONS),
    .LABEL_W    (LABEL_W),
    .THR_W      (THR_W)
  ) u_cancel (
    .cand_valid (cand_valid),
    .cand_rank  (cand_rank),
    .cand_lab   (cand_labels),
    .thresh     (dup_thresh),
    .survive    (survive)
  );

  tsort_select #(
    .N_CAND    (N_CAND),
    .OUT_SLOTS (OUT_SLOTS),
    .RANK_W    (RANK_W),
    .IDX_W     (IDX_W)
  ) u_select (
    .survive    (survive),
    .cand_rank  (cand_rank),
    .slot_valid (nxt_valid),
    .slot_rank  (nxt_rank),
    .slot_idx   (nxt_idx)
  );

  // output register: the block's only state
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      best_valid <= '0;
      best_rank  <= '0;
      best_idx   <= '0;
    end else begin
      best_valid <= nxt_valid;
      best_rank  <= nxt_rank;
      best_idx   <= nxt_idx;
    end
  end

  // some candidate always survives when any input is valid
  AST_SOME_SURVIVOR: assert property (@(posedge clk) disable iff (!rst_n)
    (|cand_valid) |=> best_valid[0]); // R9

  generate
    for (genvar s = 0; s < OUT_SLOTS; s++) begin : g_chk
      AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        best_valid[s] |-> (int'(best_idx[s*IDX_W +: IDX_W]) < N_CAND)); // R4
      AST_EMPTY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !best_valid[s] |-> (best_rank[s*RANK_W +: RANK_W] == '0 &&
                            best_idx[s*IDX_W +: IDX_W] == '0)); // R5
      if (s > 0) begin : g_pair
        AST_SLOT_PACKED: assert property (@(posedge clk) disable iff (!rst_n)
          best_valid[s] |-> best_valid[s-1]); // R5
        AST_RANK_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
          best_valid[s] |->
            ((best_rank[(s-1)*RANK_W +: RANK_W] > best_rank[s*RANK_W +: RANK_W]) ||
             ((best_rank[(s-1)*RANK_W +: RANK_W] == best_rank[s*RANK_W +: RANK_W]) &&
              (best_idx[(s-1)*IDX_W +: IDX_W] < best_idx[s*IDX_W +: IDX_W])))); // R3
      end
    end
  endgenerate
endmodule

// File: tb/best3_dedup_sorter_bench.sv
module best3_dedup_sorter_bench;
  logic         clk = 1'b0;
  logic         rst_n;
  logic [1:0]   dup_thresh;
  logic [8:0]   cand_valid;
  logic [53:0]  cand_rank;
  logic [107:0] cand_labels;
  logic [2:0]   best_valid;
  logic [17:0]  best_rank;
  logic [11:0]  best_idx;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  best3_dedup_sorter u_best3_dedup_sorter (
    .clk         (clk),
    .rst_n       (rst_n),
    .dup_thresh  (dup_thresh),
    .cand_valid  (cand_valid),
    .cand_rank   (cand_rank),
    .cand_labels (cand_labels),
    .best_valid  (best_valid),
    .best_rank   (best_rank),
    .best_idx    (best_idx)
  );

  typedef struct packed {
    logic [1:0]   thr;
    logic [8:0]   vld;
    logic [53:0]  rnk;
    logic [107:0] lab;
    logic [32:0]  exp;
  } vec_t;

  function automatic logic [53:0] rk(int a0, int a1, int a2, int a3, int a4,
                                     int a5, int a6, int a7, int a8);
    return {6'(a8), 6'(a7), 6'(a6), 6'(a5), 6'(a4), 6'(a3), 6'(a2), 6'(a1), 6'(a0)};
  endfunction

  function automatic logic [11:0] lb(int s0, int s1, int s2, int s3);
    return {3'(s3), 3'(s2), 3'(s1), 3'(s0)};
  endfunction

  function automatic logic [107:0] lb9(logic [11:0] c0, logic [11:0] c1, logic [11:0] c2,
                                       logic [11:0] c3, logic [11:0] c4, logic [11:0] c5,
                                       logic [11:0] c6, logic [11:0] c7, logic [11:0] c8);
    return {c8, c7, c6, c5, c4, c3, c2, c1, c0};
  endfunction

  function automatic logic [32:0] ex(logic [2:0] v, int r0, int i0, int r1, int i1,
                                     int r2, int i2);
    return {v, 6'(r2), 6'(r1), 6'(r0), 4'(i2), 4'(i1), 4'(i0)};
  endfunction

  localparam logic [11:0] NL = 12'h000;
  localparam int NV = 10;

  localparam vec_t TBL [NV] = '{
    // all valid, no labels: three highest ranks
    '{2'd1, 9'h1FF, rk(10,11,12,13,14,15,16,17,18), lb9(NL,NL,NL,NL,NL,NL,NL,NL,NL),
      ex(3'b111, 18,8, 17,7, 16,6)},
    // two valid, invalid ones carry high ranks
    '{2'd0, 9'h024, rk(63,63,5,63,63,9,63,63,63), lb9(NL,NL,NL,NL,NL,NL,NL,NL,NL),
      ex(3'b011, 9,5, 5,2, 0,0)},
    // cross-stream pair shares 2 > 1: weaker cand0 dropped
    '{2'd1, 9'h01B, rk(20,25,0,30,15,0,0,0,0),
      lb9(lb(1,2,3,0),NL,NL,lb(1,2,0,0),NL,NL,NL,NL,NL), ex(3'b111, 30,3, 25,1, 15,4)},
    // same pair, 2 not > 2: kept
    '{2'd2, 9'h01B, rk(20,25,0,30,15,0,0,0,0),
      lb9(lb(1,2,3,0),NL,NL,lb(1,2,0,0),NL,NL,NL,NL,NL), ex(3'b111, 30,3, 25,1, 20,0)},
    // identical labels inside one stream: no cancel
    '{2'd0, 9'h007, rk(20,30,10,0,0,0,0,0,0),
      lb9(lb(1,2,3,4),lb(1,2,3,4),NL,NL,NL,NL,NL,NL,NL), ex(3'b111, 30,1, 20,0, 10,2)},
    // zero labels never shared
    '{2'd0, 9'h049, rk(40,0,0,35,0,0,30,0,0),
      lb9(lb(0,0,2,0),NL,NL,lb(0,0,3,0),NL,NL,NL,NL,NL), ex(3'b111, 40,0, 35,3, 30,6)},
    // threshold 3, four shared, equal rank: higher index dropped
    '{2'd3, 9'h092, rk(0,20,0,0,20,0,0,20,0),
      lb9(NL,lb(1,1,1,1),NL,NL,lb(1,1,1,1),NL,NL,NL,NL), ex(3'b011, 20,1, 20,7, 0,0)},
    // chain: cancelled cand3 still cancels cand6
    '{2'd0, 9'h04B, rk(50,10,0,40,0,0,30,0,0),
      lb9(lb(1,0,0,0),NL,NL,lb(1,2,0,0),NL,NL,lb(0,2,0,0),NL,NL), ex(3'b011, 50,0, 10,1, 0,0)},
    // all equal rank: lowest indices first
    '{2'd0, 9'h1FF, rk(7,7,7,7,7,7,7,7,7), lb9(NL,NL,NL,NL,NL,NL,NL,NL,NL),
      ex(3'b111, 7,0, 7,1, 7,2)},
    // nothing valid: all slots empty
    '{2'd0, 9'h000, rk(1,2,3,4,5,6,7,8,9), lb9(NL,NL,NL,NL,NL,NL,NL,NL,NL),
      ex(3'b000, 0,0, 0,0, 0,0)}
  };

  localparam string TAG [NV] = '{"R4", "R5", "R7 R9", "R7", "R8",
                                 "R6", "R11 R9 R3", "R10", "R3", "R5"};

  task automatic drive(vec_t v);
    dup_thresh  = v.thr;
    cand_valid  = v.vld;
    cand_rank   = v.rnk;
    cand_labels = v.lab;
  endtask

  task automatic check(string req, logic [32:0] expv);
    logic [32:0] act;
    act = {best_valid, best_rank, best_idx};
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  initial begin
    rst_n       = 1'b0;
    dup_thresh  = '0;
    cand_valid  = '0;
    cand_rank   = '0;
    cand_labels = '0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R1 reset state", 33'h0);
    // R1: valid inputs while held in reset do not reach the outputs
    drive(TBL[0]);
    @(negedge clk);
    check("R1 inputs during reset", 33'h0);
    rst_n = 1'b1;

    for (int n = 0; n < NV; n++) begin
      drive(TBL[n]);
      @(negedge clk);
      check(TAG[n], TBL[n].exp);
    end

    // R2: one-cycle latency, nothing changes between edges
    drive(TBL[0]);
    @(negedge clk);
    check("R2 load", TBL[0].exp);
    drive(TBL[1]);
    #2;
    check("R2 hold before edge", TBL[0].exp);
    @(negedge clk);
    check("R2 after edge", TBL[1].exp);

    // R1: asynchronous clear in mid-cycle
    drive(TBL[0]);
    @(negedge clk);
    #3 rst_n = 1'b0;
    #1;
    check("R1 async clear", 33'h0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 recovery", TBL[0].exp);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(20 * 5000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule